// File: doc/BRIEF.md
# Memory Operation Issue Gate

This block decides whether the memory operation at the head of the instruction queue may leave it. It records the effective address of every load and every store that has issued and not yet finished, in two small address buffers. An incoming request carries its kind (load or store), its address and, for a store, the data it will write. Addresses arrive in program order, so every recorded operation is older than the request being judged. A load is compared only against recorded stores. A store is compared against both recorded loads and recorded stores. Operations whose addresses differ never hold each other up.

When a check finds a conflict, the gate raises `hold` and the queue keeps the request at its head. It presents the request again on each following cycle until the conflicting entry reports completion. Completion clears the entry's valid bit at the clock edge, so the held request can issue in the next cycle. When the forwarding mode is on, a load that hits a recorded store does not wait. It issues at once with the store's data on `fwd_data` and takes no load buffer entry. A request also waits when the buffer it needs is full. Each granted load or store gets a buffer slot number, and the memory side returns that number on completion.

Top module: `memop_issue_gate`

## Requirements
- R1: After reset both buffers are empty, so the first load and the first store issue whatever their addresses.
- R2: With forwarding off, a load whose address equals that of a recorded store gets `hold`=1 and `issue_ok`=0.
- R3: A load is never checked against recorded loads. A load to the same address as a recorded load issues.
- R4: A store whose address equals that of a recorded load gets `hold`=1.
- R5: A store whose address equals that of a recorded store gets `hold`=1. As a result, at most one recorded store ever holds a given address.
- R6: A load or store whose address matches no entry it is checked against issues (`issue_ok`=1, `hold`=0), in whatever order such requests arrive.
- R7: A completion pulse (`ld_done`/`st_done` with slot index) clears that entry at the clock edge. A request held by that entry still sees `hold`=1 in the completion cycle and issues in the next cycle.
- R8: With `fwd_en`=1, a load that matches a recorded store issues with `fwd_hit`=1 and `fwd_data` equal to that store's data. It does so even when the load buffer is full, and it takes no load slot.
- R9: A load waits (`hold`=1) when all LD_N load entries are valid. A store waits when all ST_N store entries are valid.
- R10: A granted load or store that allocates is given the lowest free slot of its buffer on `slot_id`.
- R11: `issue_ok` and `hold` are never both 1. Both are 0, as is `fwd_hit`, when `req_valid`=0. `fwd_hit`=1 only on an issuing load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fwd_en | input | 1 | 1: a load that matches a store takes the store's data instead of waiting |
| req_valid | input | 1 | A memory operation is at the queue head |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Effective address of the request |
| req_wdata | input | DW | Store data (ignored for loads) |
| ld_done | input | 1 | A load entry has completed |
| ld_done_idx | input | IDW | Slot of the completed load |
| st_done | input | 1 | A store entry has completed |
| st_done_idx | input | IDW | Slot of the completed store |
| issue_ok | output | 1 | The request leaves the queue this cycle |
| hold | output | 1 | The queue must keep the request and retry |
| slot_id | output | IDW | Slot allocated to the issuing request |
| fwd_hit | output | 1 | The issuing load is served from a store |
| fwd_data | output | DW | Forwarded store data |

## Verification
The bench aims at the completion cycle itself. A gate that compared against next-state valid bits would release a held request one cycle early, and one that missed the clear would hold it forever. It checks that a load repeating the address of a recorded load still goes through. A symmetric checker would stall it. It fills each buffer and then watches for the refused request and for the lowest-slot reuse after a completion. A wrong free-slot pick would hand out a busy or wrong index. It also sends a forwarded load into a full load buffer, which a gate that tested fullness first would wrongly hold.

// File: rtl/memop_pkg.sv
package memop_pkg;

    typedef enum logic {
        OP_LOAD  = 1'b0,
        OP_STORE = 1'b1
    } op_kind_e;

endpackage

// File: rtl/mg_pick.sv
module mg_pick #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic [N-1:0]   req,
    output logic           any,
    output logic [IDW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDW'(i);
            end
        end
    end

endmodule

// File: rtl/mg_addr_cam.sv
module mg_addr_cam #(
    parameter int N   = 4,
    parameter int AW  = 12,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           alloc_v,
    input  logic [AW-1:0]  alloc_addr,
    input  logic           free_v,
    input  logic [IDW-1:0] free_idx,
    input  logic [AW-1:0]  look_addr,
    output logic [N-1:0]   hit_vec,
    output logic           full,
    output logic [IDW-1:0] slot
);

    typedef struct packed {
        logic [N-1:0]         vld;
        logic [N-1:0][AW-1:0] adr;
    } cam_t;

    cam_t s_d, s_q;
    logic any_free;

    mg_pick #(.N(N), .IDW(IDW)) u_free (
        .req (~s_q.vld),
        .any (any_free),
        .idx (slot)
    );

    assign full = ~any_free;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = s_q.vld[g] && (s_q.adr[g] == look_addr);
    end

    always_comb begin
        s_d = s_q;
        if (free_v) begin
            s_d.vld[free_idx] = 1'b0;
        end
        if (alloc_v) begin
            s_d.vld[slot] = 1'b1;
            s_d.adr[slot] = alloc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/mg_data_bank.sv
module mg_data_bank #(
    parameter int N   = 4,
    parameter int DW  = 16,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_v,
    input  logic [IDW-1:0] wr_idx,
    input  logic [DW-1:0]  wr_data,
    input  logic [IDW-1:0] rd_idx,
    output logic [DW-1:0]  rd_data
);

    typedef logic [N-1:0][DW-1:0] bank_t;

    bank_t m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (wr_v) m_d[wr_idx] = wr_data;
    end

    assign rd_data = m_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

endmodule

// File: rtl/memop_issue_gate.sv
module memop_issue_gate
    import memop_pkg::*;
#(
    parameter int AW   = 12,
    parameter int DW   = 16,
    parameter int LD_N = 4,
    parameter int ST_N = 4,
    localparam int IDW = $clog2((LD_N > ST_N) ? LD_N : ST_N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fwd_en,
    input  logic           req_valid,
    input  logic           req_store,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic           ld_done,
    input  logic [IDW-1:0] ld_done_idx,
    input  logic           st_done,
    input  logic [IDW-1:0] st_done_idx,
    output logic           issue_ok,
    output logic           hold,
    output logic [IDW-1:0] slot_id,
    output logic           fwd_hit,
    output logic [DW-1:0]  fwd_data
);

    op_kind_e         kind;
    logic [LD_N-1:0]  ld_hit;
    logic [ST_N-1:0]  st_hit;
    logic             ld_full, st_full;
    logic [IDW-1:0]   ld_slot, st_slot, st_idx;
    logic             st_any, ld_any;
    logic             ld_alloc, st_alloc;
    logic [DW-1:0]    bank_rd;

    assign kind   = op_kind_e'(req_store);
    assign ld_any = |ld_hit;

    mg_addr_cam #(.N(LD_N), .AW(AW), .IDW(IDW)) u_ld_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_v    (ld_alloc),
        .alloc_addr (req_addr),
        .free_v     (ld_done),
        .free_idx   (ld_done_idx),
        .look_addr  (req_addr),
        .hit_vec    (ld_hit),
        .full       (ld_full),
        .slot       (ld_slot)
    );

    mg_addr_cam #(.N(ST_N), .AW(AW), .IDW(IDW)) u_st_cam (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_v    (st_alloc),
        .alloc_addr (req_addr),
        .free_v     (st_done),
        .free_idx   (st_done_idx),
        .look_addr  (req_addr),
        .hit_vec    (st_hit),
        .full       (st_full),
        .slot       (st_slot)
    );

    // Store-to-store checks keep at most one match, so a plain pick suffices.
    mg_pick #(.N(ST_N), .IDW(IDW)) u_st_match (
        .req (st_hit),
        .any (st_any),
        .idx (st_idx)
    );

    mg_data_bank #(.N(ST_N), .DW(DW), .IDW(IDW)) u_st_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_v    (st_alloc),
        .wr_idx  (st_slot),
        .wr_data (req_wdata),
        .rd_idx  (st_idx),
        .rd_data (bank_rd)
    );

    always_comb begin
        issue_ok = 1'b0;
        hold     = 1'b0;
        fwd_hit  = 1'b0;
        ld_alloc = 1'b0;
        st_alloc = 1'b0;
        if (req_valid) begin
            case (kind)
                OP_LOAD: begin
                    if (st_any) begin
                        if (fwd_en) begin
                            issue_ok = 1'b1;
                            fwd_hit  = 1'b1;
                        end else begin
                            hold = 1'b1;
                        end
                    end else if (ld_full) begin
                        hold = 1'b1;
                    end else begin
                        issue_ok = 1'b1;
                        ld_alloc = 1'b1;
                    end
                end
                default: begin
                    if (st_any || ld_any || st_full) begin
                        hold = 1'b1;
                    end else begin
                        issue_ok = 1'b1;
                        st_alloc = 1'b1;
                    end
                end
            endcase
        end
    end

    assign slot_id  = st_alloc ? st_slot : ld_slot;
    assign fwd_data = fwd_hit ? bank_rd : '0;

endmodule

// File: rtl/memop_issue_gate_chk.sv
module memop_issue_gate_chk #(
    parameter int LD_N = 4,
    parameter int ST_N = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_store,
    input logic            fwd_en,
    input logic            issue_ok,
    input logic            hold,
    input logic            fwd_hit,
    input logic            ld_full,
    input logic [LD_N-1:0] ld_hit,
    input logic [ST_N-1:0] st_hit
);

    p_no_dual_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(issue_ok && hold));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!issue_ok && !hold && !fwd_hit));

    p_store_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_hit));

    p_ld_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && (|st_hit) && !fwd_en) |-> hold);

    p_st_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && (|ld_hit)) |-> hold);

    p_fwd_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_hit |-> (issue_ok && !req_store && fwd_en));

    p_full_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && ld_full && !(|st_hit)) |-> hold);

endmodule

bind memop_issue_gate memop_issue_gate_chk #(.LD_N(LD_N), .ST_N(ST_N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .fwd_en    (fwd_en),
    .issue_ok  (issue_ok),
    .hold      (hold),
    .fwd_hit   (fwd_hit),
    .ld_full   (ld_full),
    .ld_hit    (ld_hit),
    .st_hit    (st_hit)
);

// File: tb/memop_issue_gate_test.sv
`timescale 1ns/1ps
module memop_issue_gate_test;

    localparam int AW = 12, DW = 16, LD_N = 4, ST_N = 4, IDW = 2;

    logic clk = 1'b0, rst_n = 1'b0, fwd_en = 1'b0;
    logic req_valid = 1'b0, req_store = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic ld_done = 1'b0, st_done = 1'b0;
    logic [IDW-1:0] ld_done_idx = '0, st_done_idx = '0;
    logic issue_ok, hold, fwd_hit;
    logic [IDW-1:0] slot_id;
    logic [DW-1:0] fwd_data;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    bit obs_ok, obs_hold;

    bit            m_ld_v [LD_N];
    logic [AW-1:0] m_ld_a [LD_N];
    bit            m_st_v [ST_N];
    logic [AW-1:0] m_st_a [ST_N];
    logic [DW-1:0] m_st_d [ST_N];

    always #4 clk = ~clk;

    memop_issue_gate #(.AW(AW), .DW(DW), .LD_N(LD_N), .ST_N(ST_N)) uut (
        .clk(clk), .rst_n(rst_n), .fwd_en(fwd_en),
        .req_valid(req_valid), .req_store(req_store),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .ld_done(ld_done), .ld_done_idx(ld_done_idx),
        .st_done(st_done), .st_done_idx(st_done_idx),
        .issue_ok(issue_ok), .hold(hold), .slot_id(slot_id),
        .fwd_hit(fwd_hit), .fwd_data(fwd_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit rv, input bit st, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit lc, input logic [IDW-1:0] li,
                        input bit sc, input logic [IDW-1:0] si);
        int sm = -1, lfree = -1, sfree = -1;
        bit lm = 0, e_ok = 0, e_hold = 0, e_fwd = 0, alloc = 0;
        logic [IDW-1:0] e_slot = '0;
        string tag = "R11";
        for (int i = 0; i < ST_N; i++) begin
            if (m_st_v[i] && m_st_a[i] == a && sm < 0) sm = i;
            if (!m_st_v[i] && sfree < 0) sfree = i;
        end
        for (int i = 0; i < LD_N; i++) begin
            if (m_ld_v[i] && m_ld_a[i] == a) lm = 1;
            if (!m_ld_v[i] && lfree < 0) lfree = i;
        end
        if (rv && !st) begin
            if (sm >= 0) begin
                if (fwd_en) begin e_ok = 1; e_fwd = 1; tag = "R8"; end
                else begin e_hold = 1; tag = "R2"; end
            end else if (lfree < 0) begin e_hold = 1; tag = "R9"; end
            else begin e_ok = 1; alloc = 1; e_slot = IDW'(lfree); tag = lm ? "R3" : "R6"; end
        end else if (rv) begin
            if (sm >= 0) begin e_hold = 1; tag = "R5"; end
            else if (lm) begin e_hold = 1; tag = "R4"; end
            else if (sfree < 0) begin e_hold = 1; tag = "R9"; end
            else begin e_ok = 1; alloc = 1; e_slot = IDW'(sfree); tag = "R6"; end
        end
        @(negedge clk);
        req_valid = rv; req_store = st; req_addr = a; req_wdata = d;
        ld_done = lc; ld_done_idx = li; st_done = sc; st_done_idx = si;
        #1;
        obs_ok = issue_ok; obs_hold = hold;
        chk(tag, {31'd0, issue_ok}, {31'd0, e_ok});
        chk(tag, {31'd0, hold}, {31'd0, e_hold});
        chk(tag, {31'd0, fwd_hit}, {31'd0, e_fwd});
        if (e_fwd) chk("R8", {16'd0, fwd_data}, {16'd0, m_st_d[sm]});
        if (alloc) chk("R10", {30'd0, slot_id}, {30'd0, e_slot});
        if (lc) m_ld_v[li] = 0;
        if (sc) m_st_v[si] = 0;
        if (alloc && !st) begin m_ld_v[lfree] = 1; m_ld_a[lfree] = a; end
        if (alloc && st) begin m_st_v[sfree] = 1; m_st_a[sfree] = a; m_st_d[sfree] = d; end
        @(posedge clk);
    endtask

    task automatic idle();
        step(0, 0, '0, '0, 0, '0, 0, '0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed_word;
        seed_word = $urandom(32'h5eed_1234);
        for (int i = 0; i < LD_N; i++) begin m_ld_v[i] = 0; m_ld_a[i] = '0; end
        for (int i = 0; i < ST_N; i++) begin m_st_v[i] = 0; m_st_a[i] = '0; m_st_d[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        chk("R1", {31'd0, issue_ok}, 32'd0);
        chk("R1", {31'd0, hold}, 32'd0);
        idle();
        // R1: empty buffers accept both kinds
        step(1, 0, 12'h003, '0, 0, '0, 0, '0);
        chk("R1", {31'd0, obs_ok}, 32'd1);
        step(1, 0, 12'h003, '0, 0, '0, 0, '0);      // R3 same-address load
        step(1, 1, 12'h003, 16'h1111, 0, '0, 0, '0); // R4 store vs load
        step(1, 1, 12'h005, 16'h2222, 0, '0, 0, '0); // R6
        step(1, 1, 12'h005, 16'h3333, 0, '0, 0, '0); // R5
        // R7: completion cycle still holds, next cycle issues
        step(1, 0, 12'h005, '0, 0, '0, 1, 2'd0);
        chk("R7", {31'd0, obs_hold}, 32'd1);
        step(1, 0, 12'h005, '0, 0, '0, 0, '0);
        chk("R7", {31'd0, obs_ok}, 32'd1);
        // R9: load buffer full
        step(1, 0, 12'h009, '0, 0, '0, 0, '0);
        step(1, 0, 12'h00b, '0, 0, '0, 0, '0);
        chk("R9", {31'd0, obs_hold}, 32'd1);
        step(1, 0, 12'h00b, '0, 1, 2'd1, 0, '0);
        step(1, 0, 12'h00b, '0, 0, '0, 0, '0);      // R10 reuses slot 1
        chk("R10", {31'd0, obs_ok}, 32'd1);
        // R8: forwarding into a full load buffer
        step(1, 1, 12'h007, 16'h00ab, 0, '0, 0, '0);
        fwd_en = 1'b1;
        step(1, 0, 12'h007, '0, 0, '0, 0, '0);
        chk("R8", {31'd0, obs_ok}, 32'd1);
        fwd_en = 1'b0;
        for (int i = 0; i < 4; i++) step(0, 0, '0, '0, 1, IDW'(i), 1, IDW'(i));
        // R9: store buffer full
        for (int i = 0; i < ST_N + 1; i++) step(1, 1, AW'(32 + i), DW'(i), 0, '0, 0, '0);
        chk("R9", {31'd0, obs_hold}, 32'd1);
        for (int i = 0; i < 4; i++) step(0, 0, '0, '0, 1, IDW'(i), 1, IDW'(i));
        // random phase
        for (int n = 0; n < 4000; n++) begin
            if (n % 500 == 0) fwd_en = ~fwd_en;
            step(($urandom % 5) != 0, $urandom % 2, AW'($urandom % 6), DW'($urandom),
                 ($urandom % 3) == 0, IDW'($urandom), ($urandom % 3) == 0, IDW'($urandom));
        end
        done = 1;
        summary();
        $finish;
    end

endmodule